// File: doc/BRIEF.md
# Pulse Accumulator with Event Flags

This block counts activity on a single external pin in the bus clock domain. In event mode every edge of the chosen polarity adds one to a 16-bit count. In gated mode the pin acts as a gate: while it sits at its active level, each tick of an externally supplied prescaled clock enable adds one. The pin first passes through a two-flop synchronizer, followed by an edge-detect flop. A change on the pin therefore reaches the count on the third rising clock edge after it was driven.

Two sticky flags go with the count. The wrap flag records a roll-over of the count from all ones to zero. The hit flag records the counted edge in event mode, or the trailing edge of the gate in gated mode. Software clears a flag by writing a one to it, and such a write only acts while the timer enable or the accumulator enable is high. An optional fast-clear input lets any read or write of the count clear both flags. The count can be written a byte at a time or as a full word in one cycle.

Top module: `pulse_accum`

## Requirements
- R1: After reset the count reads 0 and both flags (`flg_q[1]` wrap, `flg_q[0]` hit) read 0.
- R2: In event mode (`mode_gated`=0) with `acc_en`=1, each rising pin edge (`edge_sel`=0) or each falling pin edge (`edge_sel`=1) increments the count by one, on the third rising clock edge after the pin change.
- R3: In event mode each counted edge sets the hit flag `flg_q[0]`.
- R4: In gated mode (`mode_gated`=1) the count increments on every cycle where `tick_en`=1 and the synchronized pin is at its active level: high for `edge_sel`=0, low for `edge_sel`=1.
- R5: In gated mode the hit flag is set by the trailing edge of the gate (a falling pin for `edge_sel`=0, a rising pin for `edge_sel`=1) and not by its leading edge.
- R6: An increment from 0xFFFF to 0x0000 sets the wrap flag `flg_q[1]`.
- R7: A write with `flg_wr`=1 clears each flag whose `flg_wdata` bit is one, and only when `tim_en` or `acc_en` is high. Zero bits, and writes while both enables are low, leave the flags unchanged.
- R8: With `fast_clr`=1, any count access (`cnt_rd` or `cnt_wr`) clears both flags.
- R9: A count write replaces the high byte when `cnt_be[1]`=1 and the low byte when `cnt_be[0]`=1, in one cycle. It takes priority over a same-cycle increment and never sets the wrap flag.
- R10: When a flag is set and cleared in the same cycle, the flag ends up set.
- R11: With `acc_en`=0 the count does not change except by a write, and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tim_en | input | 1 | Timer enable; permits flag clears |
| acc_en | input | 1 | Accumulator enable; permits counting, flag sets and flag clears |
| mode_gated | input | 1 | 0 = event counting, 1 = gated accumulation |
| edge_sel | input | 1 | Polarity: rising / active-high gate (0), falling / active-low gate (1) |
| fast_clr | input | 1 | Any count access clears both flags |
| tick_en | input | 1 | Prescaled clock enable for gated mode |
| pin_in | input | 1 | Asynchronous accumulator input pin |
| cnt_wr | input | 1 | Count write strobe |
| cnt_rd | input | 1 | Count read strobe |
| cnt_be | input | 2 | Byte enables for count writes |
| cnt_wdata | input | 16 | Count write data |
| flg_wr | input | 1 | Flag write strobe (write one to clear) |
| flg_wdata | input | 2 | Flag write data: bit 1 wrap, bit 0 hit |
| cnt_q | output | 16 | Current count |
| flg_q | output | 2 | Flags: bit 1 wrap, bit 0 hit |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces both. In the first, a software count write meets a synchronized increment. The bench holds the gate active and ticks on every cycle, then writes the count, so the write meets a live increment. In the second, a flag clear meets a flag set. The bench issues write-one clears on every cycle while the count rolls past 0xFFFF, so a clear falls on the wrap cycle. A behavioural model settles each collision the way R9 and R10 describe, and the bench compares count and flags with the model on every clock.

// File: rtl/pacc_pkg.sv
`timescale 1ns/1ps
package pacc_pkg;
  typedef enum logic {
    PACC_EVENT = 1'b0,
    PACC_GATED = 1'b1
  } pacc_mode_e;

  // bit 1 = wrap, bit 0 = hit
  typedef struct packed {
    logic wrap;
    logic hit;
  } pacc_flags_t;
endpackage

// File: rtl/pacc_sync.sv
`timescale 1ns/1ps
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign prev = prev_q;
endmodule

// File: rtl/pacc_detect.sv
`timescale 1ns/1ps
module pacc_detect
  import pacc_pkg::*;
(
  input  pacc_mode_e mode,
  input  logic       edge_sel,
  input  logic       acc_en,
  input  logic       tick_en,
  input  logic       lvl,
  input  logic       prev,
  output logic       inc,
  output logic       hit_set
);
  logic rise, fall;

  always_comb begin
    rise = lvl & ~prev;
    fall = ~lvl & prev;
    case (mode)
      PACC_GATED: begin
        inc     = acc_en & tick_en & (lvl ^ edge_sel);
        hit_set = acc_en & (edge_sel ? rise : fall);
      end
      default: begin
        inc     = acc_en & (edge_sel ? fall : rise);
        hit_set = inc;
      end
    endcase
  end
endmodule

// File: rtl/pacc_counter.sv
`timescale 1ns/1ps
module pacc_counter #(
  parameter int WIDTH = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inc,
  input  logic                 wr,
  input  logic [WIDTH/8-1:0]   be,
  input  logic [WIDTH-1:0]     wdata,
  output logic [WIDTH-1:0]     cnt,
  output logic                 wrap
);
  localparam int NBYTES = WIDTH / 8;

  logic [WIDTH-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    cnt_d  = cnt_q;
    wrap   = 1'b0;
    cnt_ce = wr | inc;
    if (wr) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (be[b]) cnt_d[b*8 +: 8] = wdata[b*8 +: 8];
      end
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
      wrap  = &cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r9_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (&be)) |=> cnt_q == $past(wdata));
  a_r6_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> cnt_q == '0);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(cnt_q));
endmodule

// File: rtl/pacc_flags.sv
`timescale 1ns/1ps
module pacc_flags
  import pacc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_wrap,
  input  logic        set_hit,
  input  logic        en_any,
  input  logic        fast_clr,
  input  logic        access,
  input  logic        flg_wr,
  input  logic [1:0]  flg_wdata,
  output pacc_flags_t flags
);
  pacc_flags_t q, d;
  logic        clr_wrap, clr_hit, fast_hit, ce;

  always_comb begin
    fast_hit = fast_clr & access;
    clr_wrap = fast_hit | (flg_wr & en_any & flg_wdata[1]);
    clr_hit  = fast_hit | (flg_wr & en_any & flg_wdata[0]);
    d.wrap   = set_wrap | (q.wrap & ~clr_wrap);
    d.hit    = set_hit  | (q.hit  & ~clr_hit);
    ce       = set_wrap | set_hit | clr_wrap | clr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ce) q <= d;
  end

  assign flags = q;

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wrap || set_hit) |=> ((!$past(set_wrap) || q.wrap) && (!$past(set_hit) || q.hit)));
  a_r7_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (q.hit && flg_wr && !en_any && !(fast_clr && access)) |=> q.hit);
  a_r8_fast_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_clr && access && !set_wrap && !set_hit) |=> (q == '0));
endmodule

// File: rtl/pulse_accum.sv
`timescale 1ns/1ps
module pulse_accum
  import pacc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tim_en,
  input  logic               acc_en,
  input  logic               mode_gated,
  input  logic               edge_sel,
  input  logic               fast_clr,
  input  logic               tick_en,
  input  logic               pin_in,
  input  logic               cnt_wr,
  input  logic               cnt_rd,
  input  logic [WIDTH/8-1:0] cnt_be,
  input  logic [WIDTH-1:0]   cnt_wdata,
  input  logic               flg_wr,
  input  logic [1:0]         flg_wdata,
  output logic [WIDTH-1:0]   cnt_q,
  output logic [1:0]         flg_q
);
  logic        lvl, prev, inc, hit_set, wrap;
  pacc_flags_t flags;
  pacc_mode_e  mode;

  assign mode = pacc_mode_e'(mode_gated);

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in), .lvl(lvl), .prev(prev)
  );

  pacc_detect u_detect (
    .mode(mode), .edge_sel(edge_sel), .acc_en(acc_en), .tick_en(tick_en),
    .lvl(lvl), .prev(prev), .inc(inc), .hit_set(hit_set)
  );

  pacc_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(inc), .wr(cnt_wr), .be(cnt_be),
    .wdata(cnt_wdata), .cnt(cnt_q), .wrap(wrap)
  );

  pacc_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_wrap(wrap), .set_hit(hit_set),
    .en_any(tim_en | acc_en), .fast_clr(fast_clr), .access(cnt_wr | cnt_rd),
    .flg_wr(flg_wr), .flg_wdata(flg_wdata), .flags(flags)
  );

  assign flg_q = flags;

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !cnt_wr) |=> $stable(cnt_q));
  a_r6_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !cnt_wr && inc && (&cnt_q)) |=> flg_q[1]);
endmodule

// File: tb/tb_pulse_accum.sv
`timescale 1ns/1ps
module tb_pulse_accum;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tim_en, acc_en, mode_gated, edge_sel, fast_clr, tick_en, pin_in;
  logic        cnt_wr, cnt_rd, flg_wr;
  logic [1:0]  cnt_be, flg_wdata;
  logic [15:0] cnt_wdata;
  logic [15:0] cnt_q;
  logic [1:0]  flg_q;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string phase    = "R1";
  logic  tick_run = 1'b0;
  logic  tick_full = 1'b0;

  always #2.5 clk = ~clk;

  pulse_accum dut (
    .clk(clk), .rst_n(rst_n), .tim_en(tim_en), .acc_en(acc_en),
    .mode_gated(mode_gated), .edge_sel(edge_sel), .fast_clr(fast_clr),
    .tick_en(tick_en), .pin_in(pin_in), .cnt_wr(cnt_wr), .cnt_rd(cnt_rd),
    .cnt_be(cnt_be), .cnt_wdata(cnt_wdata), .flg_wr(flg_wr),
    .flg_wdata(flg_wdata), .cnt_q(cnt_q), .flg_q(flg_q)
  );

  // reference model state
  int   m_cnt;
  int   m_wrap, m_hit;
  int   pin_hist[$];

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    int s, p, rise, fall, inc, hset, wset, clr_w, clr_h, acc;
    if (!rst_n) begin
      m_cnt = 0; m_wrap = 0; m_hit = 0;
      pin_hist = '{0, 0, 0};
    end else begin
      s = pin_hist[1];
      p = pin_hist[2];
      rise = (s == 1 && p == 0) ? 1 : 0;
      fall = (s == 0 && p == 1) ? 1 : 0;
      if (mode_gated) begin
        inc  = (acc_en && tick_en && (s != int'(edge_sel))) ? 1 : 0;
        hset = (acc_en && (edge_sel ? rise : fall)) ? 1 : 0;
      end else begin
        inc  = (acc_en && (edge_sel ? fall : rise)) ? 1 : 0;
        hset = inc;
      end
      wset = 0;
      if (cnt_wr) begin
        if (cnt_be[0]) m_cnt = (m_cnt & 'hFF00) | int'(cnt_wdata[7:0]);
        if (cnt_be[1]) m_cnt = (m_cnt & 'h00FF) | (int'(cnt_wdata[15:8]) << 8);
      end else if (inc) begin
        if (m_cnt == 'hFFFF) begin m_cnt = 0; wset = 1; end
        else m_cnt = m_cnt + 1;
      end
      acc   = (fast_clr && (cnt_wr || cnt_rd)) ? 1 : 0;
      clr_w = (acc || (flg_wr && (tim_en || acc_en) && flg_wdata[1])) ? 1 : 0;
      clr_h = (acc || (flg_wr && (tim_en || acc_en) && flg_wdata[0])) ? 1 : 0;
      m_wrap = wset ? 1 : (clr_w ? 0 : m_wrap);
      m_hit  = hset ? 1 : (clr_h ? 0 : m_hit);
      pin_hist.push_front(int'(pin_in));
      void'(pin_hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(phase, "count", int'(cnt_q), m_cnt);
      chk(phase, "flags", int'(flg_q), (m_wrap << 1) | m_hit);
    end
    tick_en <= tick_full ? 1'b1 : (tick_run ? ~tick_en : 1'b0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected at most 20000", cycles);
      finish_run();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) pin_in = ~pin_in;
      idle(2);
      @(negedge clk) pin_in = ~pin_in;
      idle(2);
    end
    idle(3);
  endtask

  task automatic wr_cnt(logic [1:0] be, logic [15:0] d);
    @(negedge clk); cnt_wr = 1'b1; cnt_be = be; cnt_wdata = d;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wr_flg(logic [1:0] d);
    @(negedge clk); flg_wr = 1'b1; flg_wdata = d;
    @(negedge clk); flg_wr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tim_en = 0; acc_en = 0; mode_gated = 0; edge_sel = 0;
    fast_clr = 0; tick_en = 0; pin_in = 0; cnt_wr = 0; cnt_rd = 0;
    cnt_be = 0; flg_wr = 0; flg_wdata = 0; cnt_wdata = 0;
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1: reset state
    chk("R1", "count", int'(cnt_q), 0);
    chk("R1", "flags", int'(flg_q), 0);

    // R2 / R3: rising-edge event counting and hit flag
    phase = "R2"; tim_en = 1; acc_en = 1;
    pulses(5);
    chk("R2", "count", int'(cnt_q), 5);
    chk("R3", "hit", int'(flg_q[0]), 1);

    // R7: clear hit by writing one while enabled; zero bit ignored
    phase = "R7";
    wr_flg(2'b00);
    idle(1);
    chk("R7", "hit kept", int'(flg_q[0]), 1);
    wr_flg(2'b01);
    idle(1);
    chk("R7", "hit cleared", int'(flg_q), 0);

    // R2: falling-edge selection
    phase = "R2"; edge_sel = 1;
    pulses(3);
    chk("R2", "count", int'(cnt_q), 8);

    // R9 / R6: word write then wrap
    phase = "R9";
    wr_cnt(2'b11, 16'hFFFE);
    idle(1);
    chk("R9", "word write", int'(cnt_q), 'hFFFE);
    phase = "R6";
    pulses(2);
    chk("R6", "wrapped count", int'(cnt_q), 0);
    chk("R6", "wrap flag", int'(flg_q), 3);

    // R7: clears ignored while both enables low
    phase = "R7"; tim_en = 0; acc_en = 0;
    wr_flg(2'b11);
    idle(1);
    chk("R7", "locked flags", int'(flg_q), 3);
    tim_en = 1;
    wr_flg(2'b10);
    idle(1);
    chk("R7", "wrap only cleared", int'(flg_q), 1);

    // R8: fast clear by a read access
    phase = "R8"; acc_en = 1; fast_clr = 1;
    pulses(1);
    @(negedge clk) cnt_rd = 1;
    @(negedge clk) cnt_rd = 0;
    idle(1);
    chk("R8", "fast clear", int'(flg_q), 0);
    fast_clr = 0;

    // R9: byte writes
    phase = "R9";
    wr_cnt(2'b10, 16'h12AA);
    wr_cnt(2'b01, 16'hBB34);
    idle(1);
    chk("R9", "byte writes", int'(cnt_q), 'h1234);

    // R11: accumulator disabled
    phase = "R11"; acc_en = 0;
    pulses(3);
    chk("R11", "count held", int'(cnt_q), 'h1234);
    chk("R11", "no hit", int'(flg_q[0]), 0);

    // R4 / R5: gated, active-high gate
    phase = "R4"; acc_en = 1; mode_gated = 1; edge_sel = 0; tick_run = 1;
    idle(3);
    @(negedge clk) pin_in = 1;
    idle(12);
    chk("R5", "no hit on leading edge", int'(flg_q[0]), 0);
    phase = "R5";
    @(negedge clk) pin_in = 0;
    idle(5);
    chk("R5", "hit on trailing edge", int'(flg_q[0]), 1);
    wr_flg(2'b01);

    // R4 / R5: gated, active-low gate (pin low counts)
    phase = "R4"; edge_sel = 1;
    idle(8);
    phase = "R5";
    @(negedge clk) pin_in = 1;
    idle(5);
    chk("R5", "trailing rise hit", int'(flg_q[0]), 1);
    tick_run = 0;

    // R9 / R10: collisions with every-cycle ticks, gate active
    phase = "R9"; edge_sel = 0; tick_full = 1;
    idle(4);
    wr_cnt(2'b11, 16'hFFFC);
    idle(1);
    phase = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); flg_wr = 1; flg_wdata = 2'b11;
    end
    @(negedge clk) flg_wr = 0;
    idle(2);
    wr_cnt(2'b11, 16'h0100);
    idle(1);
    tick_full = 0;
    @(negedge clk) pin_in = 0;
    idle(5);
    finish_run();
  end
endmodule